// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Clear-to-Send Pacing

This block serialises characters onto a single asynchronous line. A producer offers one character at a time on a valid/ready stream. Each accepted character goes out least significant bit first, framed by a low start bit and one or two high stop bits. The number of data bits is five to eight, chosen per character. A one-cycle baud tick input paces the line, and every bit occupies a fixed number of ticks.

Three plain control inputs may change at any time: the character length, the stop length and the flow-control enable. The block reads the length and stop settings when it accepts a character, so a change made mid-frame applies from the next frame. When flow control is on, an active-low clear-to-send input can hold back new characters, but it never interrupts one that is already on the line. The block samples that input once per frame, at the frame midpoint. If the input is still asserted at that moment, the block has committed to sending one more character, even if the input drops later in the frame. Resumption after a hold raises no error indication.

Back-pressure rules: `in_ready` is high only when a new frame may begin. The producer keeps `in_valid` and `in_data` steady until a cycle with both high. That cycle is the transfer. `in_ready` never depends on `in_valid`.

Top module: `uart_cts_tx`

## Requirements
- R1: A character is taken on a clock edge where `in_valid` and `in_ready` are both high, and the start bit appears on `txd` in the next cycle. While a frame is in progress, `in_ready` is low except in the cycle carrying the final tick of the last stop bit. Every accepted character is transmitted, in acceptance order.
- R2: A frame is a start bit (0), then the data bits least significant first, then the stop bits (1). Each bit lasts TICKS_PER_BIT baud ticks, and `txd` holds steady between ticks.
- R3: `cfg_len` selects the data bit count: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7, 2'b11 gives 8.
- R4: `in_data` bits at and above the selected data bit count are never sent. The stop bit directly follows data bit count-1.
- R5: `cfg_two_stop` = 0 sends one stop bit, and 1 sends two. The line is high when the last stop bit ends.
- R6: The length and stop settings are captured at acceptance. Changing them during a frame leaves that frame's duration and content unchanged.
- R7: With `cfg_flow_en` = 0, `cts_n` has no effect. An idle transmitter shows `in_ready` = 1, and a character already waiting starts exactly when the previous frame ends, with no idle gap.
- R8: With flow control on, if `cts_n` is high before the frame midpoint, the current frame completes and no further frame starts. The midpoint is the start of bit index floor(N/2), where N is the total bit count and the start bit is index 0.
- R9: With flow control on, if `cts_n` is low at the midpoint and goes high later in the frame, exactly one more character is sent, starting straight after, and then transmission holds.
- R10: While held, `txd` = 1, `busy` = 0 and `in_ready` = 0. When `cts_n` returns low (after a two-flop synchroniser), the next pending character is sent, with no error output.
- R11: After reset, `txd` = 1, `busy` = 0, and `in_ready` = 1 when flow control is off.
- R12: `busy` is high from the first cycle of the start bit through the last stop bit, and `txd` is 1 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse, TICKS_PER_BIT per bit |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Block can start a frame now |
| cfg_len | input | 2 | Data bit count select |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_flow_en | input | 1 | 1 = obey `cts_n` |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame on the line |

## Verification
The bench builds the block with TICKS_PER_BIT = 8 and a two-stage synchroniser, and drives the baud tick on every clock. Frames are therefore 56 to 88 cycles long, and the midpoint of an eight-bit, one-stop frame falls exactly 40 cycles after the start bit. This lets the bench drop clear-to-send well before or well after that point, covering both the hold-after-this-frame case and the one-more-frame case within a few hundred cycles. Fixed frame lengths also let the bench check the spacing of back-to-back start bits exactly, which shows both the zero-gap hand-over and the capture of settings at acceptance.

// File: rtl/uart_cts_tx_pkg.sv
package uart_cts_tx_pkg;
  localparam int CHAR_MAX  = 8;
  localparam int FRAME_MAX = 1 + CHAR_MAX + 2;
  localparam int IDX_W     = $clog2(FRAME_MAX);

  typedef enum logic [1:0] {
    LEN5 = 2'b00,
    LEN6 = 2'b01,
    LEN7 = 2'b10,
    LEN8 = 2'b11
  } char_len_e;

  typedef struct packed {
    char_len_e len;
    logic      two_stop;
  } frame_cfg_t;

  function automatic logic [3:0] data_bits(char_len_e l);
    return 4'd5 + {2'b00, 2'(l)};
  endfunction

  // total bits on the line: start + data + stop(s)
  function automatic logic [IDX_W-1:0] frame_bits(frame_cfg_t c);
    return IDX_W'(data_bits(c.len)) + (c.two_stop ? IDX_W'(3) : IDX_W'(2));
  endfunction

  // unused upper bits forced to mark so they can never read as data
  function automatic logic [CHAR_MAX-1:0] fill_unused(logic [CHAR_MAX-1:0] d,
                                                      char_len_e l);
    logic [CHAR_MAX-1:0] keep;
    keep = 8'hFF >> (2'd3 - 2'(l));
    return d | ~keep;
  endfunction
endpackage

// File: rtl/tx_cts_sync.sv
module tx_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n_async,
  output logic cts_ok
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], cts_n_async};
  end

  assign cts_ok = ~chain[STAGES-1];
endmodule

// File: rtl/tx_baud_count.sv
module tx_baud_count #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic baud_tick,
  output logic bit_end
);
  localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart)          cnt <= '0;
    else if (run && baud_tick) cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
  end

  assign bit_end = run && baud_tick && (cnt == LAST);
endmodule

// File: rtl/tx_frame_shift.sv
module tx_frame_shift
  import uart_cts_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CHAR_MAX-1:0] load_data,
  input  frame_cfg_t          load_cfg,
  input  logic                bit_end,
  output logic                active,
  output logic                txd,
  output logic                last_bit,
  output logic                mid_edge
);
  logic [FRAME_MAX-1:0] shreg;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W-1:0]     nbits;
  logic [IDX_W-1:0]     half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '1;
      idx    <= '0;
      nbits  <= IDX_W'(FRAME_MAX);
      active <= 1'b0;
    end else if (load) begin
      shreg  <= {2'b11, fill_unused(load_data, load_cfg.len), 1'b0};
      idx    <= '0;
      nbits  <= frame_bits(load_cfg);
      active <= 1'b1;
    end else if (bit_end) begin
      shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
      if (last_bit) begin
        idx    <= '0;
        active <= 1'b0;
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end

  assign half     = nbits >> 1;
  assign last_bit = (idx == nbits - IDX_W'(1));
  assign mid_edge = bit_end && ((idx + IDX_W'(1)) == half);
  assign txd      = shreg[0];
endmodule

// File: rtl/tx_flow_gate.sv
module tx_flow_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic flow_en,
  input  logic cts_ok,
  input  logic active,
  input  logic mid_edge,
  input  logic frame_done,
  input  logic accept,
  output logic can_start
);
  logic mid_ok;
  logic credit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_ok <= 1'b0;
      credit <= 1'b0;
    end else begin
      if (accept)        mid_ok <= 1'b0;
      else if (mid_edge) mid_ok <= cts_ok;
      if (accept)          credit <= 1'b0;
      else if (frame_done) credit <= mid_ok;
    end
  end

  assign can_start = !flow_en || cts_ok || (active ? mid_ok : credit);
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
  import uart_cts_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] cfg_len,
  input  logic       cfg_two_stop,
  input  logic       cfg_flow_en,
  input  logic       cts_n,
  output logic       txd,
  output logic       busy
);
  logic       cts_ok;
  logic       bit_end;
  logic       active;
  logic       last_bit;
  logic       mid_edge;
  logic       frame_done;
  logic       can_start;
  logic       accept;
  frame_cfg_t cfg_now;

  assign cfg_now.len      = char_len_e'(cfg_len);
  assign cfg_now.two_stop = cfg_two_stop;

  tx_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cts_n_async(cts_n), .cts_ok(cts_ok)
  );

  tx_baud_count #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(active), .restart(accept),
    .baud_tick(baud_tick), .bit_end(bit_end)
  );

  tx_frame_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(in_data),
    .load_cfg(cfg_now), .bit_end(bit_end), .active(active), .txd(txd),
    .last_bit(last_bit), .mid_edge(mid_edge)
  );

  tx_flow_gate u_gate (
    .clk(clk), .rst_n(rst_n), .flow_en(cfg_flow_en), .cts_ok(cts_ok),
    .active(active), .mid_edge(mid_edge), .frame_done(frame_done),
    .accept(accept), .can_start(can_start)
  );

  assign frame_done = bit_end && last_bit;
  assign in_ready   = (!active || frame_done) && can_start;
  assign accept     = in_valid && in_ready;
  assign busy       = active;
endmodule

// File: rtl/uart_cts_tx_chk.sv
module uart_cts_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic in_valid,
  input logic in_ready,
  input logic cfg_flow_en,
  input logic txd,
  input logic busy
);
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R12

  AST_START_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> busy && !txd); // R1

  AST_NO_READY_MIDBIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !baud_tick |-> !in_ready); // R1

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !baud_tick |=> $stable(txd)); // R2

  AST_END_ON_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> txd); // R5

  AST_FLOW_OFF_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cfg_flow_en |-> in_ready); // R7
endmodule

bind uart_cts_tx uart_cts_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_valid(in_valid),
  .in_ready(in_ready), .cfg_flow_en(cfg_flow_en), .txd(txd), .busy(busy)
);

// File: tb/sim_uart_cts_tx.sv
module sim_uart_cts_tx;
  localparam int TPB = 8;

  typedef struct {
    logic [7:0] data;
    logic [1:0] len;
    logic       two;
    string      tag;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] cfg_len = 2'b11;
  logic       cfg_two_stop = 1'b0;
  logic       cfg_flow_en = 1'b0;
  logic       cts_n = 1'b1;
  logic       txd;
  logic       busy;

  int checks = 0;
  int fails = 0;
  int frames_done = 0;
  int cyc = 0;
  int starts [0:31];
  sb_item_t sb_q [$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_cts_tx #(.TICKS_PER_BIT(TPB), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .cfg_len(cfg_len),
    .cfg_two_stop(cfg_two_stop), .cfg_flow_en(cfg_flow_en), .cts_n(cts_n),
    .txd(txd), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] l,
                      input logic two, input string tag);
    sb_item_t it;
    @(negedge clk);
    in_data = d; cfg_len = l; cfg_two_stop = two; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    it.data = d; it.len = l; it.two = two; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // monitor: decode frames at bit centres and compare with the queue
  initial begin : monitor
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        sb_item_t it;
        int nb;
        int st;
        logic [11:0] got;
        logic [11:0] exp;
        st = cyc;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R1", "frame with nothing accepted", 32'd1, 32'd0);
          wait (txd === 1'b1);
        end else begin
          it = sb_q.pop_front();
          nb = 1 + 5 + int'(it.len) + (it.two ? 2 : 1);
          got = '1;
          exp = '1;
          exp[0] = 1'b0;
          for (int i = 0; i < 5 + int'(it.len); i++) exp[i+1] = it.data[i];
          repeat (TPB/2) @(negedge clk);
          got[0] = txd;
          for (int b = 1; b < nb; b++) begin
            repeat (TPB) @(negedge clk);
            got[b] = txd;
          end
          chk(got == exp, it.tag, "frame bits", 32'(got), 32'(exp));
          if (frames_done < 32) starts[frames_done] = st;
          frames_done++;
        end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish", 32'd0, 32'd1);
    finish_run();
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(txd == 1'b1, "R11", "txd after reset", 32'(txd), 32'd1);
    chk(busy == 1'b0, "R11", "busy after reset", 32'(busy), 32'd0);
    chk(in_ready == 1'b1, "R11", "ready after reset", 32'(in_ready), 32'd1);

    // flow off, cts negated: ignored, frames back to back (R7), cfg per frame
    send(8'hA7, 2'b11, 1'b0, "R2 R3");
    send(8'h9B, 2'b00, 1'b1, "R4 R5");
    send(8'h3F, 2'b01, 1'b0, "R3 R6");
    send(8'h55, 2'b10, 1'b1, "R4 R5");
    wait (frames_done == 4);
    wait (busy == 1'b0);
    chk(starts[1] - starts[0] == 10*TPB, "R7 R6", "gap frame0->1",
        32'(starts[1] - starts[0]), 32'(10*TPB));
    chk(starts[2] - starts[1] == 8*TPB, "R5 R6", "gap frame1->2",
        32'(starts[2] - starts[1]), 32'(8*TPB));
    chk(starts[3] - starts[2] == 8*TPB, "R3 R7", "gap frame2->3",
        32'(starts[3] - starts[2]), 32'(8*TPB));

    // R10 held from idle, then released
    @(negedge clk);
    cfg_flow_en = 1'b1;
    repeat (5) @(negedge clk);
    fork send(8'h3C, 2'b11, 1'b0, "R10"); join_none
    repeat (100) @(negedge clk);
    chk(frames_done == 4, "R10", "frames while held", 32'(frames_done), 32'd4);
    chk(busy == 1'b0 && txd == 1'b1, "R10", "line while held",
        {30'd0, busy, txd}, 32'd1);
    chk(in_ready == 1'b0, "R10", "ready while held", 32'(in_ready), 32'd0);
    cts_n = 1'b0;
    wait (frames_done == 5);
    wait (busy == 1'b0);
    repeat (5) @(negedge clk);

    // R8 negate before midpoint: stop after current frame
    fork begin
      send(8'h11, 2'b11, 1'b0, "R8");
      send(8'h22, 2'b11, 1'b0, "R8");
      send(8'h33, 2'b11, 1'b0, "R8");
    end join_none
    @(posedge busy);
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R12", "busy during frame", 32'(busy), 32'd1);
    cts_n = 1'b1;
    repeat (250) @(negedge clk);
    chk(frames_done == 6, "R8", "frames after early negate",
        32'(frames_done), 32'd6);
    chk(busy == 1'b0 && txd == 1'b1, "R8 R12", "idle after early negate",
        {30'd0, busy, txd}, 32'd1);
    cts_n = 1'b0;
    wait (frames_done == 8);
    wait (busy == 1'b0);
    repeat (5) @(negedge clk);

    // R9 negate after midpoint: one more character goes out
    fork begin
      send(8'h44, 2'b11, 1'b0, "R9");
      send(8'h66, 2'b11, 1'b0, "R9");
      send(8'h77, 2'b11, 1'b0, "R9");
    end join_none
    @(posedge busy);
    repeat (60) @(negedge clk);
    cts_n = 1'b1;
    repeat (300) @(negedge clk);
    chk(frames_done == 10, "R9", "frames after late negate",
        32'(frames_done), 32'd10);
    chk(starts[9] - starts[8] == 10*TPB, "R9", "extra frame immediate",
        32'(starts[9] - starts[8]), 32'(10*TPB));
    chk(in_ready == 1'b0 && busy == 1'b0, "R10", "held after extra frame",
        {30'd0, in_ready, busy}, 32'd0);
    cts_n = 1'b0;
    wait (frames_done == 11);
    wait (busy == 1'b0);
    repeat (5) @(negedge clk);
    chk(sb_q.size() == 0, "R1 R10", "pending after resume",
        32'(sb_q.size()), 32'd0);
    finish_run();
  end
endmodule